// File: doc/BRIEF.md
# Command Buffer DMA Loader

This block moves a buffer of tagged command words from host memory into the command input FIFO, so that software does not have to poll for free FIFO space word by word. Software first writes the buffer's byte address into the start-address register. It then writes the number of 32-bit words into the length register. That second write starts the engine, and software is free to do other work until the transfer ends.

While running, the engine issues single-word reads on a simple request/grant memory port. Each returned word goes straight into the command FIFO, which is the same FIFO that direct host writes feed. A read is only issued when the FIFO reports more free entries than there are reads still in flight, so a returned word always finds room. Reading the length register gives the words still to be delivered. A value of zero means the engine is idle.

Top module: `cmd_dma_loader`

## Requirements
- R1: A configuration write with `cfg_wr_sel`=0 stores the start address with its two low bits cleared. The first read of the next transfer uses that address.
- R2: A configuration write with `cfg_wr_sel`=1 while idle takes bits [15:0] of `cfg_wr_data` as the word count and ignores the bits above them. A nonzero count raises `busy`, and `remaining_words` equals the count, one cycle after the write.
- R3: A count write of zero starts nothing. `busy` stays low and no read is issued.
- R4: A transfer of N words issues exactly N accepted reads. Each accepted read's address is 4 greater than the previous one.
- R5: Every read response while busy is pushed into the FIFO in the same cycle, in request order. `remaining_words` drops by one in the cycle after each push.
- R6: A read is requested only when `fifo_free` is greater than the number of accepted reads not yet answered, and never with more than 4 reads in flight. The FIFO never overflows, and nothing is requested while `fifo_free` is 0.
- R7: A request that is not granted stays asserted with an unchanged address in the next cycle.
- R8: Configuration writes to either register while `busy` is high have no effect on the running transfer or on the stored start address.
- R9: `busy` is high exactly while `remaining_words` is nonzero. It falls in the cycle after the last push, and no read is requested while idle.
- R10: After reset, `remaining_words` is 0, `busy` is low, and no read or push is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0: start-address register, 1: length register |
| cfg_wr_data | input | 32 | Configuration write data |
| remaining_words | output | 16 | Length register read value: words still to deliver |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, returned in request order |
| mem_rdata | input | 32 | Read data |
| fifo_free | input | 6 | Free entries in the command FIFO |
| fifo_push | output | 1 | Push one word into the command FIFO |
| fifo_wdata | output | 32 | Word pushed into the FIFO |

## Verification
The register effects of a configuration write (`busy`, `remaining_words`, the start address) become visible one cycle after the write edge. The bench therefore reads them at the falling edge that follows the write. A request follows combinationally from the current free-space value, and a push happens in the same cycle as its response. The bench's memory and FIFO models drive their inputs at the falling edge and read `mem_req` and `fifo_push` a moment later, before the next rising edge. `remaining_words` lags each push by one edge, so the model compares it against the count of pushes already logged at the next falling edge.

// File: rtl/cmd_dma_pkg.sv
package cmd_dma_pkg;

    localparam int ADDR_W     = 32;
    localparam int REG_W      = 32;
    localparam int WORD_BYTES = 4;

    typedef enum logic {
        SEL_START_ADDR = 1'b0,
        SEL_LENGTH     = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic             en;
        cfg_sel_e         sel;
        logic [REG_W-1:0] data;
    } cfg_wr_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'(WORD_BYTES - 1);
    endfunction

    function automatic logic [ADDR_W-1:0] next_word_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/cmd_dma_regs.sv
module cmd_dma_regs
    import cmd_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_wr_t           wr,
    input  logic              word_done,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              busy,
    output logic              start
);

    logic [CNT_W-1:0] len_field;
    logic             unused_cfg_bits;

    assign len_field       = wr.data[CNT_W-1:0];
    assign unused_cfg_bits = ^wr.data;

    assign busy  = (remaining != '0);
    assign start = wr.en && (wr.sel == SEL_LENGTH) && !busy && (len_field != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            remaining <= '0;
        end else begin
            if (wr.en && !busy && (wr.sel == SEL_START_ADDR))
                base_addr <= word_align(wr.data[ADDR_W-1:0]);
            if (start)
                remaining <= len_field;
            else if (word_done && busy)
                remaining <= remaining - 1'b1;
        end
    end

endmodule

// File: rtl/cmd_dma_credit.sv
module cmd_dma_credit #(
    parameter int FREE_W  = 6,
    parameter int MAX_OUT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issued,
    input  logic              retired,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              room
);

    localparam int OUT_W = $clog2(MAX_OUT + 1);

    logic [OUT_W-1:0] in_flight;
    logic             can_retire;

    assign can_retire = retired && (in_flight != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= '0;
        end else begin
            case ({issued, can_retire})
                2'b10:   in_flight <= in_flight + 1'b1;
                2'b01:   in_flight <= in_flight - 1'b1;
                default: in_flight <= in_flight;
            endcase
        end
    end

    assign room = (32'(fifo_free) > 32'(in_flight)) && (32'(in_flight) < MAX_OUT);

endmodule

// File: rtl/cmd_dma_issue.sv
module cmd_dma_issue
    import cmd_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_len,
    input  logic              room,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              issued
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    assign mem_req  = (left_q != '0) && room;
    assign mem_addr = addr_q;
    assign issued   = mem_req && mem_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (start) begin
            addr_q <= start_addr;
            left_q <= start_len;
        end else if (issued) begin
            addr_q <= next_word_addr(addr_q);
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/cmd_dma_loader.sv
module cmd_dma_loader
    import cmd_dma_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int FREE_W  = 6,
    parameter int MAX_OUT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [CNT_W-1:0]  remaining_words,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [REG_W-1:0]  mem_rdata,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_push,
    output logic [REG_W-1:0]  fifo_wdata
);

    cfg_wr_t           cfg_wr;
    logic [ADDR_W-1:0] base_addr;
    logic              start;
    logic              room;
    logic              issued;
    logic              word_done;

    assign cfg_wr.en   = cfg_wr_en;
    assign cfg_wr.sel  = cfg_sel_e'(cfg_wr_sel);
    assign cfg_wr.data = cfg_wr_data;

    assign word_done  = mem_rvalid && busy;
    assign fifo_push  = word_done;
    assign fifo_wdata = mem_rdata;

    cmd_dma_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .word_done (word_done),
        .base_addr (base_addr),
        .remaining (remaining_words),
        .busy      (busy),
        .start     (start)
    );

    cmd_dma_credit #(.FREE_W(FREE_W), .MAX_OUT(MAX_OUT)) u_credit (
        .clk       (clk),
        .rst       (rst),
        .issued    (issued),
        .retired   (mem_rvalid),
        .fifo_free (fifo_free),
        .room      (room)
    );

    cmd_dma_issue #(.CNT_W(CNT_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (base_addr),
        .start_len  (cfg_wr_data[CNT_W-1:0]),
        .room       (room),
        .mem_gnt    (mem_gnt),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .issued     (issued)
    );

endmodule

// File: rtl/cmd_dma_loader_chk.sv
module cmd_dma_loader_chk #(
    parameter int CNT_W  = 16,
    parameter int FREE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic              cfg_wr_sel,
    input logic [31:0]       cfg_wr_data,
    input logic [CNT_W-1:0]  remaining_words,
    input logic              busy,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic              mem_gnt,
    input logic [FREE_W-1:0] fifo_free,
    input logic              fifo_push
);

    logic unused_chk_bits;
    assign unused_chk_bits = ^cfg_wr_data;

    // R10
    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> (remaining_words == '0 && !mem_req && !fifo_push));

    p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_wr_en && cfg_wr_sel && cfg_wr_data[CNT_W-1:0] != '0)
        |=> (busy && remaining_words == $past(cfg_wr_data[CNT_W-1:0])));

    p_zero_len_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_wr_en && cfg_wr_sel && cfg_wr_data[CNT_W-1:0] == '0) |=> !busy);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> (!mem_req || mem_addr == $past(mem_addr) + 32'd4));

    p_push_busy_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> busy);

    p_push_dec_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> remaining_words == $past(remaining_words) - 1'b1);

    p_no_req_full_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_free == '0) |-> !mem_req);

    p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_wr_en && !fifo_push) |=> remaining_words == $past(remaining_words));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

endmodule

bind cmd_dma_loader cmd_dma_loader_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_wr_en       (cfg_wr_en),
    .cfg_wr_sel      (cfg_wr_sel),
    .cfg_wr_data     (cfg_wr_data),
    .remaining_words (remaining_words),
    .busy            (busy),
    .mem_req         (mem_req),
    .mem_addr        (mem_addr),
    .mem_gnt         (mem_gnt),
    .fifo_free       (fifo_free),
    .fifo_push       (fifo_push)
);

// File: tb/cmd_dma_loader_bench.sv
`timescale 1ns/1ps
module cmd_dma_loader_bench;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] first;
        logic [15:0] len;
        logic [7:0]  cap;
        logic [7:0]  drain;
        logic        gnt_alt;
    } vec_t;

    // stimulus: written base, length, FIFO capacity, drain period, grant pattern
    // expected: first read address (low bits cleared), word count = len
    localparam vec_t VECS [4] = '{
        '{32'h1000_0000, 32'h1000_0000, 16'd5,  8'd8,  8'd1, 1'b0},
        '{32'h2000_0103, 32'h2000_0100, 16'd12, 8'd3,  8'd3, 1'b0},
        '{32'h0000_FFF2, 32'h0000_FFF0, 16'd9,  8'd16, 8'd0, 1'b1},
        '{32'h3000_0000, 32'h3000_0000, 16'd1,  8'd1,  8'd2, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [15:0] remaining_words;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [5:0]  fifo_free = '0;
    logic        fifo_push;
    logic [31:0] fifo_wdata;

    always #2.5 clk = ~clk;

    cmd_dma_loader u_cmd_dma_loader (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .remaining_words(remaining_words), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_free(fifo_free),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cap = 0, drain_per = 0, gnt_alt = 0, occ = 0;
    int overflow_cnt = 0, rem_err = 0;
    bit trk = 0;
    int trk_len = 0;
    logic [31:0] push_log [$];
    logic [31:0] req_log  [$];
    logic [31:0] pend_addr [$];
    int          pend_due  [$];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory and FIFO models: drive at the falling edge, sample just after
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst) begin
            mem_rvalid = 1'b0;
            fifo_free  = '0;
        end else begin
            if (trk && int'(remaining_words) != trk_len - push_log.size()) rem_err++;
            fifo_free = (cap > occ) ? 6'(cap - occ) : 6'd0;
            mem_gnt   = (gnt_alt == 0) ? 1'b1 : cyc[0];
            if (pend_addr.size() > 0 && pend_due[0] <= cyc) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(pend_addr[0]);
                void'(pend_addr.pop_front());
                void'(pend_due.pop_front());
            end else begin
                mem_rvalid = 1'b0;
            end
            #1;
            if (mem_req && mem_gnt) begin
                req_log.push_back(mem_addr);
                pend_addr.push_back(mem_addr);
                pend_due.push_back(cyc + 2);
            end
            if (fifo_push) begin
                if (occ >= cap) overflow_cnt++;
                else occ++;
                push_log.push_back(fifo_wdata);
            end
            if (drain_per > 0 && occ > 0 && (cyc % drain_per) == 0) occ--;
        end
    end

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic begin_xfer(input bit do_base, input logic [31:0] base,
                              input logic [31:0] len_word, input int exp_len,
                              input int c, input int d, input int g);
        cap = c; drain_per = d; gnt_alt = g; occ = 0;
        push_log.delete(); req_log.delete();
        overflow_cnt = 0; rem_err = 0;
        if (do_base) cfg_write(1'b0, base);
        cfg_write(1'b1, len_word);
        check(busy == 1'b1, "R2", "busy after length write", busy, 1);
        check(int'(remaining_words) == exp_len, "R2", "length loaded", remaining_words, exp_len);
        trk = 1; trk_len = exp_len;
    endtask

    task automatic end_xfer(input logic [31:0] first, input int exp_len);
        int guard = 0;
        int data_bad = 0;
        int addr_bad = 0;
        while ((busy || pend_addr.size() > 0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        #2;
        trk = 0;
        check(!busy, "R9", "busy low after last word", busy, 0);
        check(remaining_words == 16'd0, "R9", "remaining zero at end", remaining_words, 0);
        check(req_log.size() == exp_len, "R4", "accepted read count", req_log.size(), exp_len);
        check(push_log.size() == exp_len, "R5", "pushed word count", push_log.size(), exp_len);
        foreach (req_log[i])
            if (req_log[i] != first + 32'(4 * i)) addr_bad++;
        foreach (push_log[i])
            if (push_log[i] != mem_word(first + 32'(4 * i))) data_bad++;
        check(addr_bad == 0, "R1/R4", "read address sequence errors", addr_bad, 0);
        check(data_bad == 0, "R5", "pushed data order errors", data_bad, 0);
        check(overflow_cnt == 0, "R6", "FIFO overflows", overflow_cnt, 0);
        check(rem_err == 0, "R5", "remaining count tracking errors", rem_err, 0);
    endtask

    initial begin
        int stall_bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // R10 reset state
        check(remaining_words == 16'd0, "R10", "remaining after reset", remaining_words, 0);
        check(!busy, "R10", "busy after reset", busy, 0);
        check(!mem_req, "R10", "mem_req after reset", mem_req, 0);
        check(!fifo_push, "R10", "fifo_push after reset", fifo_push, 0);

        // table walk (R7 exercised by the alternating-grant rows)
        for (int i = 0; i < 4; i++) begin
            begin_xfer(1'b1, VECS[i].base, {16'h0, VECS[i].len}, int'(VECS[i].len),
                       int'(VECS[i].cap), int'(VECS[i].drain), int'(VECS[i].gnt_alt));
            end_xfer(VECS[i].first, int'(VECS[i].len));
        end

        // R3 zero length starts nothing
        cap = 8; drain_per = 1; gnt_alt = 0;
        cfg_write(1'b1, 32'h0);
        check(!busy, "R3", "busy after zero length", busy, 0);
        stall_bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #2;
            if (mem_req) stall_bad++;
        end
        check(stall_bad == 0, "R3", "reads after zero length", stall_bad, 0);

        // R2 bits above 15 ignored
        begin_xfer(1'b1, 32'h5000_0000, 32'h0003_0004, 4, 8, 1, 0);
        end_xfer(32'h5000_0000, 4);

        // R6 no read while FIFO has no free entry
        begin_xfer(1'b1, 32'h4000_0000, 32'd3, 3, 0, 0, 0);
        stall_bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #2;
            if (mem_req) stall_bad++;
        end
        check(stall_bad == 0, "R6", "reads issued with full FIFO", stall_bad, 0);
        check(remaining_words == 16'd3, "R6", "remaining during stall", remaining_words, 3);
        cap = 4; drain_per = 1;
        end_xfer(32'h4000_0000, 3);

        // R8 writes while busy are ignored
        begin_xfer(1'b1, 32'h6000_0000, 32'd8, 8, 1, 6, 0);
        cfg_write(1'b0, 32'h7000_0000);
        cfg_write(1'b1, 32'd3);
        end_xfer(32'h6000_0000, 8);
        // start address must still be the one written while idle
        begin_xfer(1'b0, 32'h0, 32'd2, 2, 4, 1, 0);
        end_xfer(32'h6000_0000, 2);
        check(req_log.size() > 0 && req_log[0] == 32'h6000_0000, "R8",
              "start address after ignored write", (req_log.size() > 0) ? req_log[0] : 0,
              32'h6000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule